// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block turns simple read and write requests into the command sequence that one DRAM bank needs: open a row, access a column, and close the row again. A requester presents a request with a valid/ready handshake, a read/write flag, a row address, a column address and write data. The block drives a shared address bus and single-cycle row-open, column-strobe, write-enable and precharge commands toward the bank. It returns read data with a one-cycle valid pulse.

The block leaves the last row open after every access. A later request to the same row goes straight to the column phase. A request to a different row first closes the open row with a precharge, then opens the new row. Three parameters set the minimum spacing between phases: open-to-column, column-to-data and precharge-to-open. Each is counted in clock cycles and must be at least 2. Write data enters the bank's row latch during the column phase, and the bank stores it back to the cells when the row is closed.

Top module: `dramBankSeq`

## Requirements
- R1: After reset, and after any reset that arrives during an access, `reqReady` is 1, `rdValid` is 0, no command is driven and no row is open. The first request after reset therefore opens its row without a precharge.
- R2: At most one of `memRas`, `memCas` and `memPre` is high in any cycle, and each command lasts one cycle.
- R3: `memAddr` carries the row address, zero-extended, in the cycle of `memRas`. It carries the column address in the cycle of `memCas`.
- R4: If no row is open, a request accepted at the end of cycle a gets `memRas` in cycle a+1 and `memCas` in cycle a+1+T_RCD. A column command never follows a row-open by fewer than T_RCD cycles.
- R5: If a different row is open, a request accepted at the end of cycle a gets `memPre` in cycle a+1, `memRas` in cycle a+1+T_RP and `memCas` in cycle a+1+T_RP+T_RCD. A row is opened only when no row is open.
- R6: A request to the open row gets `memCas` in cycle a+1, with no `memRas` and no `memPre`.
- R7: A read whose `memCas` is in cycle c raises `rdValid` for exactly one cycle, in cycle c+T_CL+1. `rdData` then holds the value the bank drove on `memRdata` in cycle c+T_CL.
- R8: `memWe` is high only together with `memCas`, and only for a write. `memWdata` then carries the request's write data. A later read of that location returns it, including after the row has been closed and reopened.
- R9: `reqReady` is high only when the block is idle. Request fields that change while the block is busy do not alter the access in flight. A request held valid is taken again in the cycle read data returns.
- R10: A row stays open after an access. `memPre` is issued only when a request names a different row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken this cycle when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqWdata | input | DATA_W | Write data (DATA_W is 4, 8, 16 or 32) |
| rdValid | output | 1 | One-cycle read data pulse |
| rdData | output | DATA_W | Read data |
| memAddr | output | max(ROW_W,COL_W) | Shared row/column address to the bank |
| memRas | output | 1 | Row-open command |
| memCas | output | 1 | Column command |
| memWe | output | 1 | Column command is a write |
| memPre | output | 1 | Precharge (row close) command |
| memWdata | output | DATA_W | Write data to the bank |
| memRdata | input | DATA_W | Read data from the bank |

## Verification
Two events can fall in the same cycle: the return of read data and the acceptance of the next request, since the block is idle again in the cycle `rdValid` is high. The bench provokes this by holding `reqValid` high through a read while changing the column field mid-flight. It then checks that the first read returns the data of the originally latched column. It also checks that the second request is taken in the pulse cycle and completes as an open-row hit. A behavioural bank model in the bench flags any command that breaks the phase order or spacing.

// File: rtl/dbsPkg.sv
package dbsPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_PREW,
    S_ACT,
    S_ACTW,
    S_COL,
    S_CLW,
    S_DATA
  } dbsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic issuePre;
    logic issueRas;
    logic issueCas;
    logic captureRd;
  } dbsStrobes_t;

endpackage

// File: rtl/dbsCtrl.sv
module dbsCtrl
  import dbsPkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_CL  = 2,
  parameter int T_RP  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqHit,
  input  logic        rowOpen,
  input  logic        curWrite,
  output logic        reqReady,
  output dbsStrobes_t stb
);

  localparam int MAX_A = (T_RCD > T_CL) ? T_RCD : T_CL;
  localparam int MAX_T = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int CNT_W = $clog2(MAX_T) + 1;

  dbsState_t        state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stb       = '0;
    reqReady  = 1'b0;
    nextState = state;
    cntNext   = cnt;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          if (reqHit)       nextState = S_COL;
          else if (rowOpen) nextState = S_PRE;
          else              nextState = S_ACT;
        end
      end
      S_PRE: begin
        stb.issuePre = 1'b1;
        cntNext      = CNT_W'(T_RP - 2);
        nextState    = S_PREW;
      end
      S_PREW: begin
        if (cntZero) nextState = S_ACT;
        else         cntNext   = cnt - 1'b1;
      end
      S_ACT: begin
        stb.issueRas = 1'b1;
        cntNext      = CNT_W'(T_RCD - 2);
        nextState    = S_ACTW;
      end
      S_ACTW: begin
        if (cntZero) nextState = S_COL;
        else         cntNext   = cnt - 1'b1;
      end
      S_COL: begin
        stb.issueCas = 1'b1;
        if (curWrite) begin
          nextState = S_IDLE;
        end else begin
          cntNext   = CNT_W'(T_CL - 2);
          nextState = S_CLW;
        end
      end
      S_CLW: begin
        if (cntZero) nextState = S_DATA;
        else         cntNext   = cnt - 1'b1;
      end
      S_DATA: begin
        stb.captureRd = 1'b1;
        nextState     = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/dbsDatapath.sv
module dbsDatapath
  import dbsPkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbsStrobes_t       stb,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqHit,
  output logic              rowOpen,
  output logic              curWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRas,
  output logic              memCas,
  output logic              memWe,
  output logic              memPre,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [ROW_W-1:0]  curRow, openRow;
  logic [COL_W-1:0]  curCol;
  logic [DATA_W-1:0] curWdata;
  logic              openValid;
  logic [ADDR_W-1:0] rowOnBus, colOnBus;

  // request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow   <= '0;
      curCol   <= '0;
      curWdata <= '0;
      curWrite <= 1'b0;
    end else if (stb.latchReq) begin
      curRow   <= reqRow;
      curCol   <= reqCol;
      curWdata <= reqWdata;
      curWrite <= reqWrite;
    end
  end

  // open-row tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= 1'b0;
      openRow   <= '0;
    end else if (stb.issuePre) begin
      openValid <= 1'b0;
    end else if (stb.issueRas) begin
      openValid <= 1'b1;
      openRow   <= curRow;
    end
  end

  assign rowOpen = openValid;
  assign reqHit  = openValid && (reqRow == openRow);

  // zero extension of each address part onto the shared bus
  generate
    if (ADDR_W > ROW_W) begin : g_rowPad
      assign rowOnBus = {{(ADDR_W-ROW_W){1'b0}}, curRow};
    end else begin : g_rowFull
      assign rowOnBus = curRow;
    end
    if (ADDR_W > COL_W) begin : g_colPad
      assign colOnBus = {{(ADDR_W-COL_W){1'b0}}, curCol};
    end else begin : g_colFull
      assign colOnBus = curCol;
    end
  endgenerate

  always_comb begin
    memAddr = '0;
    if (stb.issueRas)      memAddr = rowOnBus;
    else if (stb.issueCas) memAddr = colOnBus;
  end

  assign memRas   = stb.issueRas;
  assign memCas   = stb.issueCas;
  assign memPre   = stb.issuePre;
  assign memWe    = stb.issueCas & curWrite;
  assign memWdata = curWdata;

  // read return
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.captureRd;
      if (stb.captureRd) rdData <= memRdata;
    end
  end

endmodule

// File: rtl/dramBankSeq.sv
module dramBankSeq
  import dbsPkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_CL   = 2,
  parameter int T_RP   = 2,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRas,
  output logic              memCas,
  output logic              memWe,
  output logic              memPre,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  dbsStrobes_t stb;
  logic        reqHit, rowOpen, curWrite;

  dbsCtrl #(.T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqHit   (reqHit),
    .rowOpen  (rowOpen),
    .curWrite (curWrite),
    .reqReady (reqReady),
    .stb      (stb)
  );

  dbsDatapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqWrite (reqWrite),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .reqHit   (reqHit),
    .rowOpen  (rowOpen),
    .curWrite (curWrite),
    .memAddr  (memAddr),
    .memRas   (memRas),
    .memCas   (memCas),
    .memWe    (memWe),
    .memPre   (memPre),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/dramBankSeq_chk.sv
module dramBankSeq_chk #(
  parameter int T_RCD = 3,
  parameter int T_CL  = 2,
  parameter int T_RP  = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rdValid,
  input logic memRas,
  input logic memCas,
  input logic memWe,
  input logic memPre
);

  localparam int CW = $clog2(T_RCD + T_CL + T_RP + 4) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] sinceRas, sinceCas, sincePre;
  logic          rowUp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRas <= SAT;
      sinceCas <= SAT;
      sincePre <= SAT;
      rowUp    <= 1'b0;
    end else begin
      sinceRas <= memRas ? CW'(1) : ((sinceRas == SAT) ? SAT : sinceRas + 1'b1);
      sinceCas <= memCas ? CW'(1) : ((sinceCas == SAT) ? SAT : sinceCas + 1'b1);
      sincePre <= memPre ? CW'(1) : ((sincePre == SAT) ? SAT : sincePre + 1'b1);
      if (memRas)      rowUp <= 1'b1;
      else if (memPre) rowUp <= 1'b0;
    end
  end

  a_r2_one_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRas, memCas, memPre}));

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (memRas || memCas || memPre) |=> !$past(memRas && memRas) || !memRas);

  a_r4_open_to_col: assert property (@(posedge clk) disable iff (!rstN)
    memCas |-> (rowUp && sinceRas >= CW'(T_RCD)));

  a_r5_close_to_open: assert property (@(posedge clk) disable iff (!rstN)
    memRas |-> (!rowUp && sincePre >= CW'(T_RP)));

  a_r5_close_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    memPre |-> rowUp);

  a_r7_data_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (sinceCas == CW'(T_CL + 1)));

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r8_we_with_cas: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memCas);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(memRas || memCas || memPre));

endmodule

bind dramBankSeq dramBankSeq_chk #(.T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rdValid  (rdValid),
  .memRas   (memRas),
  .memCas   (memCas),
  .memWe    (memWe),
  .memPre   (memPre)
);

// File: tb/dramBankSeq_tb.sv
`timescale 1ns/1ps
module dramBankSeq_tb;

  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int T_RCD  = 3;
  localparam int T_CL   = 4;
  localparam int T_RP   = 2;
  localparam int NROW   = 1 << ROW_W;
  localparam int NCOL   = 1 << COL_W;
  localparam int NVEC   = 11;

  // vector: {kind[1:0], write, row[3:0], col[3:0], data[7:0]}
  // kind 0 = no row open, 1 = open-row hit, 2 = other row open
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 4'h3, 4'h5, 8'h35},
    {2'd1, 1'b0, 4'h3, 4'h9, 8'h39},
    {2'd1, 1'b1, 4'h3, 4'h9, 8'hA1},
    {2'd1, 1'b0, 4'h3, 4'h9, 8'hA1},
    {2'd2, 1'b0, 4'h7, 4'h0, 8'h70},
    {2'd1, 1'b1, 4'h7, 4'h2, 8'h5C},
    {2'd2, 1'b0, 4'h3, 4'h9, 8'hA1},
    {2'd2, 1'b0, 4'h7, 4'h2, 8'h5C},
    {2'd2, 1'b1, 4'h1, 4'hF, 8'hFF},
    {2'd1, 1'b0, 4'h1, 4'hF, 8'hFF},
    {2'd2, 1'b0, 4'h0, 4'h0, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqReady, rdValid, memRas, memCas, memWe, memPre;
  logic [DATA_W-1:0] rdData, memWdata, memRdata;
  logic [ADDR_W-1:0] memAddr;

  int nChecks = 0;
  int nBad    = 0;
  int mChecks = 0;
  int mBad    = 0;

  always #4 clk = ~clk;

  dramBankSeq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memRas(memRas),
    .memCas(memCas), .memWe(memWe), .memPre(memPre), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // behavioural bank: cells, row latch, protocol and spacing checks
  logic [DATA_W-1:0] cells  [NROW][NCOL];
  logic [DATA_W-1:0] rowBuf [NCOL];
  logic              mOpen, pActive;
  logic [ROW_W-1:0]  mRow;
  logic [DATA_W-1:0] pData;
  int                pend, sinceRasM, sincePreM;

  assign memRdata = (pActive && pend == 0) ? pData : '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mOpen     <= 1'b0;
      pActive   <= 1'b0;
      pend      <= 0;
      sinceRasM <= 100;
      sincePreM <= 100;
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NCOL; c++)
          cells[r][c] <= DATA_W'(r * NCOL + c);
    end else begin
      sinceRasM <= memRas ? 1 : (sinceRasM < 100 ? sinceRasM + 1 : 100);
      sincePreM <= memPre ? 1 : (sincePreM < 100 ? sincePreM + 1 : 100);
      if (pActive) begin
        if (pend == 0) pActive <= 1'b0;
        else           pend    <= pend - 1;
      end
      if (memRas) begin
        mChecks <= mChecks + 1;
        if (mOpen || sincePreM < T_RP) begin
          mBad <= mBad + 1;
          $display("FAIL R5 bank: row open while open=%0d sincePre=%0d (expected 0, >=%0d)",
                   mOpen, sincePreM, T_RP);
        end
        mOpen <= 1'b1;
        mRow  <= memAddr;
        for (int c = 0; c < NCOL; c++) rowBuf[c] <= cells[memAddr][c];
      end
      if (memCas) begin
        mChecks <= mChecks + 1;
        if (!mOpen || sinceRasM < T_RCD) begin
          mBad <= mBad + 1;
          $display("FAIL R4 bank: column cmd open=%0d sinceRas=%0d (expected 1, >=%0d)",
                   mOpen, sinceRasM, T_RCD);
        end
        if (memWe) begin
          rowBuf[memAddr] <= memWdata;
        end else begin
          pActive <= 1'b1;
          pend    <= T_CL - 1;
          pData   <= rowBuf[memAddr];
        end
      end
      if (memPre) begin
        mChecks <= mChecks + 1;
        if (!mOpen) begin
          mBad <= mBad + 1;
          $display("FAIL R5 bank: precharge with no open row (actual open=0 expected 1)");
        end
        mOpen <= 1'b0;
        for (int c = 0; c < NCOL; c++) cells[mRow][c] <= rowBuf[c];
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runTx(input logic [1:0] kind, input logic wr, input logic [3:0] row,
                       input logic [3:0] col, input logic [7:0] data);
    int w, casAt, rdAt, rasN, preN, rasAddr, casAddr, rdD;
    bit early, multi, weBad;
    int expCas;
    @(negedge clk);
    check("R7 pulse ends", int'(rdValid), 0);
    reqValid = 1'b1; reqWrite = wr; reqRow = row; reqCol = col; reqWdata = data;
    w = 0;
    while (!reqReady && w < 50) begin @(negedge clk); w++; end
    @(negedge clk);
    reqValid = 1'b0;
    casAt = 0; rdAt = 0; rasN = 0; preN = 0; rasAddr = -1; casAddr = -1; rdD = -1;
    early = 0; multi = 0; weBad = 0;
    for (int n = 1; n <= 40; n++) begin
      if (n > 1) @(negedge clk);
      if (memRas) begin rasN++; rasAddr = int'(memAddr); end
      if (memPre) preN++;
      if (memCas) begin casAt = n; casAddr = int'(memAddr); end
      if (rdValid) begin rdAt = n; rdD = int'(rdData); end
      if (int'(memRas) + int'(memCas) + int'(memPre) > 1) multi = 1;
      if (memWe && !(memCas && wr)) weBad = 1;
      if (memCas && wr && memWdata != data) weBad = 1;
      if (reqReady && casAt == 0) early = 1;
      if (reqReady && casAt != 0 && (wr || rdAt != 0)) break;
    end
    expCas = (kind == 2'd1) ? 1 : (kind == 2'd0) ? 1 + T_RCD : 1 + T_RP + T_RCD;
    case (kind)
      2'd0: check("R4 column cycle (closed row)", casAt, expCas);
      2'd1: check("R6 column cycle (open-row hit)", casAt, expCas);
      default: check("R5 column cycle (row change)", casAt, expCas);
    endcase
    check("R6 R10 row-open count", rasN, (kind == 2'd1) ? 0 : 1);
    check("R10 precharge count", preN, (kind == 2'd2) ? 1 : 0);
    if (kind != 2'd1) check("R3 row on bus", rasAddr, int'(row));
    check("R3 column on bus", casAddr, int'(col));
    check("R2 one command per cycle", int'(multi), 0);
    check("R8 write enable and data", int'(weBad), 0);
    check("R9 ready while busy", int'(early), 0);
    if (!wr) begin
      check("R7 data valid cycle", rdAt, expCas + T_CL + 1);
      check("R7 R8 read data", rdD, int'(data));
    end
  endtask

  initial begin
    int r1, r2;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(reqReady), 1);
    check("R1 no data valid in reset", int'(rdValid), 0);
    check("R1 no command in reset", int'(memRas | memCas | memPre), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(reqReady), 1);

    for (int i = 0; i < NVEC; i++)
      runTx(VEC[i][18:17], VEC[i][16], VEC[i][15:12], VEC[i][11:8], VEC[i][7:0]);

    // R9: request held valid, column changed while busy; new take in data cycle
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqRow = 4'h9; reqCol = 4'h3;
    @(negedge clk);
    reqCol = 4'h4;
    r1 = -1; r2 = -1;
    for (int n = 0; n < 40 && r1 < 0; n++) begin
      if (rdValid) begin
        r1 = int'(rdData);
        check("R9 taken in data cycle", int'(reqReady), 1);
      end
      else @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
    check("R6 hit needs no open", int'(memRas | memPre), 0);
    check("R6 hit column now", int'(memCas), 1);
    for (int n = 0; n < 40 && r2 < 0; n++) begin
      @(negedge clk);
      if (rdValid) r2 = int'(rdData);
    end
    check("R9 in-flight fields kept", r1, 8'h93);
    check("R9 second request served", r2, 8'h94);

    // R1: reset during an access clears the open row
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqRow = 4'h2; reqCol = 4'h6;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after mid reset", int'(reqReady), 1);
    check("R1 quiet after mid reset", int'(memRas | memCas | memPre | rdValid), 0);
    runTx(2'd0, 1'b0, 4'h0, 4'h1, 8'h01);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nChecks + mChecks, nBad + mBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", nChecks + mChecks + 1, nBad + mBad + 1);
    $finish;
  end

endmodule